// File: doc/BRIEF.md
# ECC-Protected Register File with Fault Injection

This block is a 32-entry, 32-bit register file with two read ports and one write port. Every stored word carries a SECDED code: a six-bit Hamming check field plus one overall parity bit. Each word is encoded on its way into storage. Each read port has its own checker, which repairs single-bit faults and flags double-bit faults. Entry 0 is hardwired to zero.

A small control field lets test software plant a known fault. After it is written with a single or double injection code, the next write to a non-zero entry stores a corrupted word. The field then clears itself. Reading that entry through either port shows how the checkers respond.

Reads use a synchronous memory followed by a registered checker stage, so the array maps onto block RAM.

Top module: `rfe_regfile_top`

## Requirements
- R1: A read address sampled on one rising edge yields the stored word on that port's data output after the second rising edge. For a cleanly stored entry, both error flags are low.
- R2: Entry 0 always reads as zero with both flags low. Writes to entry 0 are discarded.
- R3: The injection field is two bits wide: 00 means none, 01 means single, 10 means double. Writing 11 stores 00. `ctl_rd_data` shows the current field value one edge after a control write.
- R4: An armed injection is applied to the next write to a non-zero entry. A write to entry 0 leaves the field unchanged. A write in the same cycle as a control write uses the field value held before that control write.
- R5: After a write consumes an injection, the field reads 00 from the following edge on. A control write in that same cycle takes priority.
- R6: A single injection stores the word with data bit 0 inverted. A read returns the original data with `corr` high and `uncorr` low.
- R7: A double injection stores the word with data bits 0 and 1 inverted. A read returns those corrupted data bits unchanged with `uncorr` high and `corr` low.
- R8: Ports A and B check independently. Both report the same result for the same entry, including when both read it in the same cycle.
- R9: A read of the address being written in the same cycle returns the previously stored word. The new word appears on later reads.
- R10: The `corr` and `uncorr` flags of a port are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write entry index |
| wr_data | input | 32 | Write data |
| rd_a_addr | input | 5 | Port A read index |
| rd_b_addr | input | 5 | Port B read index |
| rd_a_data | output | 32 | Port A data (corrected when possible) |
| rd_a_corr | output | 1 | Port A single-bit fault corrected |
| rd_a_uncorr | output | 1 | Port A double-bit fault detected |
| rd_b_data | output | 32 | Port B data (corrected when possible) |
| rd_b_corr | output | 1 | Port B single-bit fault corrected |
| rd_b_uncorr | output | 1 | Port B double-bit fault detected |
| ctl_wr_en | input | 1 | Injection field write strobe |
| ctl_wr_data | input | 2 | Injection code to store |
| ctl_rd_data | output | 2 | Current injection field value |

## Verification
Read results are due two rising edges after the address is applied: one edge for the memory read and one for the registered checker. The injection field changes one edge after a control write or a consuming write. The driver task applies every input just after a falling edge. It queues each read's expected word and flags, tagged with the cycle count two edges later. It then checks `ctl_rd_data` right after the next edge. The monitor samples outputs on falling edges and compares an entry only when its due count matches the current cycle.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  typedef enum logic [1:0] {
    INJ_NONE = 2'b00,
    INJ_ONE  = 2'b01,
    INJ_TWO  = 2'b10,
    INJ_RSVD = 2'b11
  } inj_mode_e;

  localparam int MAX_DATA_W = 256;

  // Number of Hamming check bits for a given data width.
  function automatic int chk_bits(input int dw);
    int k;
    k = 1;
    while ((1 << k) < dw + k + 1) k++;
    return k;
  endfunction

  // Codeword position (1-based) of data bit idx; powers of two are check slots.
  function automatic int data_pos(input int idx);
    int pos;
    int cnt;
    pos = 2;
    cnt = -1;
    while (cnt < idx) begin
      pos++;
      if ((pos & (pos - 1)) != 0) cnt++;
    end
    return pos;
  endfunction

  // Data bits covered by check bit k.
  function automatic logic [MAX_DATA_W-1:0] cover_mask(input int k, input int dw);
    logic [MAX_DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < dw; i++) begin
      if (((data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/rfe_secded_enc.sv
module rfe_secded_enc #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = rfe_pkg::chk_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              par_o
);

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [rfe_pkg::MAX_DATA_W-1:0] FULL_MASK = rfe_pkg::cover_mask(k, DATA_W);
    assign chk_o[k] = ^(data_i & FULL_MASK[DATA_W-1:0]);
  end

  assign par_o = (^data_i) ^ (^chk_o);

endmodule

// File: rtl/rfe_secded_chk.sv
module rfe_secded_chk #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = rfe_pkg::chk_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic              par_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              uncorr_o
);

  logic [CHK_W-1:0]  chk_calc;
  logic              par_unused;
  logic [CHK_W-1:0]  syndrome;
  logic              overall;
  logic [DATA_W-1:0] fix_mask;

  rfe_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recalc (
    .data_i(data_i),
    .chk_o (chk_calc),
    .par_o (par_unused)
  );

  assign syndrome = chk_i ^ chk_calc;
  assign overall  = (^data_i) ^ (^chk_i) ^ par_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int POS = rfe_pkg::data_pos(i);
    assign fix_mask[i] = overall && (syndrome == CHK_W'(POS));
  end

  assign corr_o   = overall;
  assign uncorr_o = !overall && (syndrome != '0);
  assign data_o   = data_i ^ fix_mask;

  // R7: a double fault passes data through untouched
  always_comb begin
    if (uncorr_o) a_r7_double_passthru: assert (data_o == data_i);
  end

endmodule

// File: rtl/rfe_inj_ctrl.sv
module rfe_inj_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr_en,
  input  logic [1:0]        ctl_wr_data,
  input  logic              wr_fire,
  output logic [1:0]        mode_o,
  output logic [DATA_W-1:0] flip_mask_o
);
  import rfe_pkg::*;

  inj_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= INJ_NONE;
    end else if (ctl_wr_en) begin
      mode_q <= (inj_mode_e'(ctl_wr_data) == INJ_RSVD) ? INJ_NONE : inj_mode_e'(ctl_wr_data);
    end else if (wr_fire && mode_q != INJ_NONE) begin
      mode_q <= INJ_NONE;
    end
  end

  always_comb begin
    flip_mask_o = '0;
    if (wr_fire) begin
      case (mode_q)
        INJ_ONE: flip_mask_o[0] = 1'b1;
        INJ_TWO: flip_mask_o[1:0] = 2'b11;
        default: flip_mask_o = '0;
      endcase
    end
  end

  assign mode_o = mode_q;

  a_r5_self_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && mode_q != INJ_NONE && !ctl_wr_en) |=> (mode_q == INJ_NONE));

  a_r4_idle_keeps: assert property (@(posedge clk) disable iff (rst)
    (!wr_fire && !ctl_wr_en) |=> $stable(mode_q));

  a_r3_no_reserved: assert property (@(posedge clk) disable iff (rst)
    mode_q != INJ_RSVD);

endmodule

// File: rtl/rfe_ram.sv
module rfe_ram #(
  parameter int WIDTH  = 39,
  parameter int ADDR_W = 5,
  parameter int NRD    = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr [NRD],
  output logic [WIDTH-1:0]  rdata [NRD]
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end

endmodule

// File: rtl/rfe_regfile_top.sv
module rfe_regfile_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_a_data,
  output logic              rd_a_corr,
  output logic              rd_a_uncorr,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              rd_b_corr,
  output logic              rd_b_uncorr,
  input  logic              ctl_wr_en,
  input  logic [1:0]        ctl_wr_data,
  output logic [1:0]        ctl_rd_data
);

  localparam int CHK_W = rfe_pkg::chk_bits(DATA_W);
  localparam int CW    = DATA_W + CHK_W + 1;
  localparam int NRD   = 2;

  logic              wr_fire;
  logic [DATA_W-1:0] flip_mask;
  logic [CHK_W-1:0]  enc_chk;
  logic              enc_par;
  logic [CW-1:0]     wr_word;

  logic [ADDR_W-1:0] raddr   [NRD];
  logic [CW-1:0]     rword   [NRD];
  logic              zero_q  [NRD];
  logic [DATA_W-1:0] out_d_q [NRD];
  logic              out_c_q [NRD];
  logic              out_u_q [NRD];

  assign wr_fire = wr_en && (wr_addr != '0);

  rfe_inj_ctrl #(.DATA_W(DATA_W)) u_inj (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wr_data(ctl_wr_data),
    .wr_fire    (wr_fire),
    .mode_o     (ctl_rd_data),
    .flip_mask_o(flip_mask)
  );

  rfe_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i(wr_data),
    .chk_o (enc_chk),
    .par_o (enc_par)
  );

  assign wr_word = {enc_par, enc_chk, wr_data ^ flip_mask};

  assign raddr[0] = rd_a_addr;
  assign raddr[1] = rd_b_addr;

  rfe_ram #(.WIDTH(CW), .ADDR_W(ADDR_W), .NRD(NRD)) u_ram (
    .clk  (clk),
    .we   (wr_fire),
    .waddr(wr_addr),
    .wdata(wr_word),
    .raddr(raddr),
    .rdata(rword)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [DATA_W-1:0] fixed;
    logic              c_flag;
    logic              u_flag;

    always_ff @(posedge clk) begin
      if (rst) zero_q[p] <= 1'b1;
      else     zero_q[p] <= (raddr[p] == '0);
    end

    rfe_secded_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
      .data_i  (rword[p][DATA_W-1:0]),
      .chk_i   (rword[p][DATA_W +: CHK_W]),
      .par_i   (rword[p][CW-1]),
      .data_o  (fixed),
      .corr_o  (c_flag),
      .uncorr_o(u_flag)
    );

    always_ff @(posedge clk) begin
      if (rst || zero_q[p]) begin
        out_d_q[p] <= '0;
        out_c_q[p] <= 1'b0;
        out_u_q[p] <= 1'b0;
      end else begin
        out_d_q[p] <= fixed;
        out_c_q[p] <= c_flag;
        out_u_q[p] <= u_flag;
      end
    end

    a_r10_flags_excl: assert property (@(posedge clk) disable iff (rst)
      !(out_c_q[p] && out_u_q[p]));
  end

  assign rd_a_data   = out_d_q[0];
  assign rd_a_corr   = out_c_q[0];
  assign rd_a_uncorr = out_u_q[0];
  assign rd_b_data   = out_d_q[1];
  assign rd_b_corr   = out_c_q[1];
  assign rd_b_uncorr = out_u_q[1];

  a_r2_zero_read_a: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_a_addr, 2) == '0) |-> (rd_a_data == '0 && !rd_a_corr && !rd_a_uncorr));

  a_r2_zero_read_b: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_b_addr, 2) == '0) |-> (rd_b_data == '0 && !rd_b_corr && !rd_b_uncorr));

endmodule

// File: tb/test_rfe_regfile_top.sv
module test_rfe_regfile_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_a_addr;
  logic [4:0]  rd_b_addr;
  logic [31:0] rd_a_data;
  logic        rd_a_corr;
  logic        rd_a_uncorr;
  logic [31:0] rd_b_data;
  logic        rd_b_corr;
  logic        rd_b_uncorr;
  logic        ctl_wr_en;
  logic [1:0]  ctl_wr_data;
  logic [1:0]  ctl_rd_data;

  always #5 clk = ~clk;

  rfe_regfile_top i_rfe_regfile_top (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .rd_a_data(rd_a_data), .rd_a_corr(rd_a_corr), .rd_a_uncorr(rd_a_uncorr),
    .rd_b_data(rd_b_data), .rd_b_corr(rd_b_corr), .rd_b_uncorr(rd_b_uncorr),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data)
  );

  typedef struct {
    int          due;
    bit          port_b;
    logic [31:0] data;
    bit          corr;
    bit          uncorr;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] mem_m [32];
  int          err_m [32];
  int          mode_m = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  // Monitor: compare results when due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t        it;
      logic [31:0] ad;
      bit          ac;
      bit          au;
      it = sbq.pop_front();
      ad = it.port_b ? rd_b_data   : rd_a_data;
      ac = it.port_b ? rd_b_corr   : rd_a_corr;
      au = it.port_b ? rd_b_uncorr : rd_a_uncorr;
      checks++;
      if (ad !== it.data || ac !== it.corr || au !== it.uncorr) begin
        fails++;
        $display("FAIL %s port %s: actual %h c%0b u%0b expected %h c%0b u%0b",
                 it.req, it.port_b ? "B" : "A", ad, ac, au, it.data, it.corr, it.uncorr);
      end
    end
  end

  function automatic exp_t predict(input logic [4:0] a, input bit pb, input string req);
    exp_t e;
    e.due = cyc + 2; e.port_b = pb; e.req = req;
    e.corr = 0; e.uncorr = 0; e.data = '0;
    if (a != 0) begin
      e.data = mem_m[a];
      if (err_m[a] == 1) e.corr = 1;
      if (err_m[a] == 2) begin e.uncorr = 1; e.data = mem_m[a] ^ 32'h3; end
    end
    return e;
  endfunction

  // Driver: one cycle of stimulus, inputs applied after a falling edge
  task automatic drive(input bit we, input logic [4:0] wa, input logic [31:0] wd,
                       input bit rda, input logic [4:0] ra,
                       input bit rdb, input logic [4:0] rb,
                       input bit cw, input logic [1:0] cd, input string req);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_a_addr = ra; rd_b_addr = rb;
    ctl_wr_en = cw; ctl_wr_data = cd;
    if (rda) sbq.push_back(predict(ra, 1'b0, req));
    if (rdb) sbq.push_back(predict(rb, 1'b1, req));
    if (we && wa != 0) begin
      mem_m[wa] = wd;
      err_m[wa] = mode_m;
      mode_m = 0;
    end
    if (cw) mode_m = (cd == 2'b11) ? 0 : int'(cd);
    @(negedge clk);
    wr_en = 0; ctl_wr_en = 0;
  endtask

  task automatic check_ctl(input string req);
    checks++;
    if (ctl_rd_data !== 2'(mode_m)) begin
      fails++;
      $display("FAIL %s ctl: actual %b expected %b", req, ctl_rd_data, 2'(mode_m));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mem_m[i] = '0; err_m[i] = 0; end
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_a_addr = 0; rd_b_addr = 0;
    ctl_wr_en = 0; ctl_wr_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // Reset state (R1, R3)
    checks++;
    if (rd_a_data !== 0 || rd_b_data !== 0 || rd_a_corr || rd_a_uncorr || rd_b_corr || rd_b_uncorr) begin
      fails++; $display("FAIL R1 reset outputs: actual %h %h expected 0", rd_a_data, rd_b_data);
    end
    check_ctl("R3 reset");

    // R1: clean writes and reads
    drive(1, 3,  32'hA5A5_0001, 0, 0, 0, 0, 0, 0, "R1");
    drive(1, 7,  32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, "R1");
    drive(1, 31, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R1");
    drive(1, 1,  32'h0000_0000, 0, 0, 0, 0, 0, 0, "R1");
    drive(0, 0, 0, 1, 3, 1, 7, 0, 0, "R1 clean read");
    drive(0, 0, 0, 1, 31, 1, 1, 0, 0, "R1 clean read");

    // R2: entry 0
    drive(1, 0, 32'h1234_5678, 0, 0, 0, 0, 0, 0, "R2");
    drive(0, 0, 0, 1, 0, 1, 0, 0, 0, "R2 zero read");

    // R3/R4/R5/R6/R8: single injection
    drive(0, 0, 0, 0, 0, 0, 0, 1, 2'b01, "R3");
    check_ctl("R3 arm single");
    drive(1, 0, 32'h55, 0, 0, 0, 0, 0, 0, "R4");
    check_ctl("R4 entry0 keeps armed");
    drive(1, 5, 32'h0F0F_F0F0, 0, 0, 0, 0, 0, 0, "R5");
    check_ctl("R5 self clear");
    drive(0, 0, 0, 1, 5, 1, 5, 0, 0, "R6 R8 single corrected");
    drive(1, 9, 32'h0000_0001, 0, 0, 0, 0, 0, 0, "R4");
    drive(0, 0, 0, 1, 9, 0, 0, 0, 0, "R4 consumed once");

    // R7: double injection
    drive(0, 0, 0, 0, 0, 0, 0, 1, 2'b10, "R3");
    check_ctl("R3 arm double");
    drive(1, 6, 32'h1234_5678, 0, 0, 0, 0, 0, 0, "R5");
    check_ctl("R5 self clear double");
    drive(0, 0, 0, 1, 6, 0, 0, 0, 0, "R7 double detected");
    drive(0, 0, 0, 0, 0, 1, 6, 0, 0, "R8 port B double");

    // R3: reserved code
    drive(0, 0, 0, 0, 0, 0, 0, 1, 2'b11, "R3");
    check_ctl("R3 reserved as none");
    drive(1, 8, 32'hCAFE_0003, 0, 0, 0, 0, 0, 0, "R3");
    drive(0, 0, 0, 1, 8, 1, 8, 0, 0, "R3 reserved no inject");

    // R9: read during write returns old
    drive(1, 3, 32'h7777_0000, 1, 3, 1, 3, 0, 0, "R9 old word");
    drive(0, 0, 0, 1, 3, 1, 3, 0, 0, "R9 new word");

    // R4: control write in same cycle as data write uses old mode
    drive(1, 10, 32'h0000_00FF, 0, 0, 0, 0, 1, 2'b01, "R4");
    check_ctl("R4 armed after same-cycle write");
    drive(1, 11, 32'h8000_0002, 1, 10, 0, 0, 0, 0, "R4 same-cycle clean");
    drive(0, 0, 0, 1, 11, 1, 11, 0, 0, "R6 late single");

    // Rewrite clears the fault
    drive(1, 5, 32'h0F0F_F0F0, 0, 0, 0, 0, 0, 0, "R1");
    drive(0, 0, 0, 1, 5, 1, 6, 0, 0, "R1 rewritten clean R7 still double");

    idle(4);
    checks++;
    if (sbq.size() != 0) begin
      fails++; $display("FAIL R1 pending: actual %0d expected 0", sbq.size());
    end
    summary();
  end

endmodule